// File: doc/BRIEF.md
# Cache Bank Line Migration Controller

This block moves every line of one cache bank into another bank after a remapping. Software first loads the new mapping into the inactive (shadow) descriptor and then pulses `start_i`. The controller then steps through the slot indices of the source bank. For each slot that holds a line, it reads the line, writes it into the same slot of the destination bank and invalidates the source copy. Slots that hold no line are skipped in a single cycle.

While the move is running, reads are never held back. A routing output tells the requester whether the slot it asks about has already reached the destination bank. Writes to lines that have not moved yet are stalled. A stalled write also promotes its line into a single priority slot, so that line moves next instead of waiting for the sequential sweep to reach it. When every slot has been handled, a one-cycle swap pulse tells the descriptor logic to exchange the active and shadow mappings.

Top module: `line_migrator`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o` from the next cycle. A `start_i` pulse while busy is ignored: progress is kept and no line is moved twice.
- R2: Each present source line is moved exactly once. The move is a source read handshake, then a destination write handshake carrying the same index and the data just read, then a source invalidate handshake for that index. Only one of the three requests is active at a time, and each request holds its index and data until it is accepted.
- R3: A slot whose bit in `present_i` is 0 is never read, written or invalidated.
- R4: When no write is stalled, lines move in strictly ascending index order.
- R5: Reads are never stalled. `rd_from_dst_o` is 1 when busy and the slot at `rd_idx_i` has moved or is absent. It is 0 otherwise, including while idle.
- R6: `wr_stall_o` is 1 only while busy for a write to a present slot that has not finished moving. It falls in the cycle after that slot's invalidate handshake. Writes while idle, and writes to absent slots, are never stalled.
- R7: A stalled write to a line that is neither moving nor already moved takes the priority slot if that slot is free. That line is the next one moved after the move in progress.
- R8: The priority slot holds one line. A later write to another unmoved line does not replace it. The later write stays stalled and can take the slot only after the held line has been launched.
- R9: After every slot is handled, `swap_o` is high for exactly one cycle, and `busy_o` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Shadow mapping loaded; begin migration |
| present_i | input | LINES | Per-slot "line held in source bank" flags |
| wr_req_i | input | 1 | Write request from the cache side |
| wr_idx_i | input | IDX_W | Slot targeted by the write |
| wr_stall_o | output | 1 | Write must wait |
| rd_idx_i | input | IDX_W | Slot targeted by a read |
| rd_from_dst_o | output | 1 | Serve that read from the destination bank |
| busy_o | output | 1 | Migration in progress |
| swap_o | output | 1 | One-cycle pulse: exchange active and shadow descriptors |
| src_rd_valid_o | output | 1 | Source bank read request |
| src_rd_idx_o | output | IDX_W | Source slot to read |
| src_rd_ready_i | input | 1 | Source read accepted, data valid |
| src_rd_data_i | input | DATA_W | Line data from source |
| dst_wr_valid_o | output | 1 | Destination write request |
| dst_wr_idx_o | output | IDX_W | Destination slot |
| dst_wr_data_o | output | DATA_W | Line data to write |
| dst_wr_ready_i | input | 1 | Destination write accepted |
| src_inv_valid_o | output | 1 | Source invalidate request |
| src_inv_idx_o | output | IDX_W | Source slot to invalidate |
| src_inv_ready_i | input | 1 | Invalidate accepted |

## Verification
The assertions assume that `present_i` stays constant from the start pulse until the swap pulse. They also assume that the source bank returns valid data in the cycle it raises `src_rd_ready_i`. The bench meets both assumptions: it changes the presence map only while idle, and it computes read data combinationally from the requested index. The bench holds a write request until the stall drops, and it changes the write target only in the one scenario built to show that the priority slot is not overwritten. Ready signals on the destination and invalidate ports are randomly withheld in some runs, so the handshake-hold properties are exercised.

// File: rtl/mig_pkg.sv
package mig_pkg;
  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE, MV_CLEAR} mv_state_e;

  // A slot still needs copying when it holds a line that has not yet arrived.
  function automatic logic needs_move(input logic held, input logic moved);
    return held && !moved;
  endfunction
endpackage

// File: rtl/mig_mover.sv
module mig_mover
  import mig_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [IDX_W-1:0]  launch_idx_i,
  output logic              idle_o,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic              fin_o,
  output logic              src_rd_valid_o,
  output logic [IDX_W-1:0]  src_rd_idx_o,
  input  logic              src_rd_ready_i,
  input  logic [DATA_W-1:0] src_rd_data_i,
  output logic              dst_wr_valid_o,
  output logic [IDX_W-1:0]  dst_wr_idx_o,
  output logic [DATA_W-1:0] dst_wr_data_o,
  input  logic              dst_wr_ready_i,
  output logic              src_inv_valid_o,
  output logic [IDX_W-1:0]  src_inv_idx_o,
  input  logic              src_inv_ready_i
);
  mv_state_e         st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= MV_IDLE;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        MV_IDLE:  if (launch_i) begin idx_q <= launch_idx_i; st_q <= MV_READ; end
        MV_READ:  if (src_rd_ready_i) begin data_q <= src_rd_data_i; st_q <= MV_WRITE; end
        MV_WRITE: if (dst_wr_ready_i) st_q <= MV_CLEAR;
        MV_CLEAR: if (src_inv_ready_i) st_q <= MV_IDLE;
        default:  st_q <= MV_IDLE;
      endcase
    end
  end

  assign idle_o          = (st_q == MV_IDLE);
  assign cur_idx_o       = idx_q;
  assign fin_o           = (st_q == MV_CLEAR) && src_inv_ready_i;
  assign src_rd_valid_o  = (st_q == MV_READ);
  assign src_rd_idx_o    = idx_q;
  assign dst_wr_valid_o  = (st_q == MV_WRITE);
  assign dst_wr_idx_o    = idx_q;
  assign dst_wr_data_o   = data_q;
  assign src_inv_valid_o = (st_q == MV_CLEAR);
  assign src_inv_idx_o   = idx_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_valid_o && !src_rd_ready_i |=> src_rd_valid_o && $stable(src_rd_idx_o));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_valid_o && !dst_wr_ready_i |=> dst_wr_valid_o && $stable(dst_wr_data_o) && $stable(dst_wr_idx_o));
  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_rd_valid_o, dst_wr_valid_o, src_inv_valid_o}));
endmodule

// File: rtl/mig_tracker.sv
module mig_tracker
  import mig_pkg::*;
#(
  parameter int LINES = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LINES-1:0] present_i,
  input  logic             wr_req_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             mover_idle_i,
  input  logic [IDX_W-1:0] mover_idx_i,
  input  logic             fin_i,
  output logic             launch_o,
  output logic [IDX_W-1:0] launch_idx_o,
  output logic             busy_o,
  output logic             swap_o,
  output logic             wr_stall_o,
  output logic             rd_from_dst_o
);
  localparam int PTR_W = IDX_W + 1;

  logic [LINES-1:0] done_q;
  logic [PTR_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_idx, prio_idx_q;
  logic             prio_v_q, busy_q, swap_q;
  logic             ptr_end, take_prio, skip_ptr, finish, capture, in_flight;

  assign ptr_idx = ptr_q[IDX_W-1:0];
  assign ptr_end = (ptr_q == PTR_W'(LINES));

  // Next-slot selection: priority line first, then the sequential sweep.
  always_comb begin
    launch_o     = 1'b0;
    launch_idx_o = ptr_idx;
    take_prio    = 1'b0;
    skip_ptr     = 1'b0;
    finish       = 1'b0;
    if (busy_q && mover_idle_i) begin
      if (prio_v_q) begin
        take_prio = 1'b1;
        if (needs_move(present_i[prio_idx_q], done_q[prio_idx_q])) begin
          launch_o     = 1'b1;
          launch_idx_o = prio_idx_q;
        end
      end else if (ptr_end) begin
        finish = 1'b1;
      end else if (needs_move(present_i[ptr_idx], done_q[ptr_idx])) begin
        launch_o = 1'b1;
      end else begin
        skip_ptr = 1'b1;
      end
    end
  end

  assign in_flight = (!mover_idle_i && mover_idx_i == wr_idx_i) ||
                     (launch_o && launch_idx_o == wr_idx_i);
  assign wr_stall_o    = busy_q && wr_req_i && needs_move(present_i[wr_idx_i], done_q[wr_idx_i]);
  assign capture       = wr_stall_o && !prio_v_q && !in_flight;
  assign rd_from_dst_o = busy_q && !needs_move(present_i[rd_idx_i], done_q[rd_idx_i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= '0;
      ptr_q      <= '0;
      prio_v_q   <= 1'b0;
      prio_idx_q <= '0;
      busy_q     <= 1'b0;
      swap_q     <= 1'b0;
    end else begin
      swap_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q   <= 1'b1;
        done_q   <= '0;
        ptr_q    <= '0;
        prio_v_q <= 1'b0;
      end else begin
        if (fin_i) done_q[mover_idx_i] <= 1'b1;
        if (skip_ptr) begin
          done_q[ptr_idx] <= 1'b1;
          ptr_q           <= ptr_q + 1'b1;
        end
        if (take_prio) prio_v_q <= 1'b0;
        else if (capture) begin
          prio_v_q   <= 1'b1;
          prio_idx_q <= wr_idx_i;
        end
        if (finish) begin
          busy_q <= 1'b0;
          swap_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign swap_o = swap_q;

  // R9
  swap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) swap_o |=> !swap_o);
  // R9
  swap_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) swap_o |-> $past(busy_o) && !busy_o);
  // R1
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> busy_o || swap_o);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i && wr_req_i && wr_idx_i == mover_idx_i |=> !(wr_stall_o && wr_idx_i == $past(mover_idx_i)));
endmodule

// File: rtl/line_migrator.sv
module line_migrator #(
  parameter  int LINES  = 256,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINES-1:0]  present_i,
  input  logic              wr_req_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  output logic              wr_stall_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_from_dst_o,
  output logic              busy_o,
  output logic              swap_o,
  output logic              src_rd_valid_o,
  output logic [IDX_W-1:0]  src_rd_idx_o,
  input  logic              src_rd_ready_i,
  input  logic [DATA_W-1:0] src_rd_data_i,
  output logic              dst_wr_valid_o,
  output logic [IDX_W-1:0]  dst_wr_idx_o,
  output logic [DATA_W-1:0] dst_wr_data_o,
  input  logic              dst_wr_ready_i,
  output logic              src_inv_valid_o,
  output logic [IDX_W-1:0]  src_inv_idx_o,
  input  logic              src_inv_ready_i
);
  logic             launch, mover_idle, fin;
  logic [IDX_W-1:0] launch_idx, mover_idx;

  mig_tracker #(.LINES(LINES), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .present_i(present_i),
    .wr_req_i(wr_req_i), .wr_idx_i(wr_idx_i), .rd_idx_i(rd_idx_i),
    .mover_idle_i(mover_idle), .mover_idx_i(mover_idx), .fin_i(fin),
    .launch_o(launch), .launch_idx_o(launch_idx), .busy_o(busy_o),
    .swap_o(swap_o), .wr_stall_o(wr_stall_o), .rd_from_dst_o(rd_from_dst_o)
  );

  mig_mover #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_move (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .launch_idx_i(launch_idx),
    .idle_o(mover_idle), .cur_idx_o(mover_idx), .fin_o(fin),
    .src_rd_valid_o(src_rd_valid_o), .src_rd_idx_o(src_rd_idx_o),
    .src_rd_ready_i(src_rd_ready_i), .src_rd_data_i(src_rd_data_i),
    .dst_wr_valid_o(dst_wr_valid_o), .dst_wr_idx_o(dst_wr_idx_o),
    .dst_wr_data_o(dst_wr_data_o), .dst_wr_ready_i(dst_wr_ready_i),
    .src_inv_valid_o(src_inv_valid_o), .src_inv_idx_o(src_inv_idx_o),
    .src_inv_ready_i(src_inv_ready_i)
  );

  // R7
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) launch |-> mover_idle);
  // R3
  present_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_valid_o |-> present_i[src_rd_idx_o]);
endmodule

// File: tb/line_migrator_tb.sv
module line_migrator_tb;
  localparam int LINES  = 256;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LINES-1:0] present = '0;
  logic wr_req = 1'b0, wr_stall, rd_dst, busy, swap;
  logic [IDX_W-1:0] wr_idx = '0, rd_idx = '0;
  logic src_rd_valid, src_rd_ready = 1'b1, dst_wr_valid, dst_wr_ready = 1'b1;
  logic src_inv_valid, src_inv_ready = 1'b1;
  logic [IDX_W-1:0] src_rd_idx, dst_wr_idx, src_inv_idx;
  logic [DATA_W-1:0] src_rd_data, dst_wr_data;
  bit jitter = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [DATA_W-1:0] pat(input int i);
    return {8'hC3, 8'(i), 16'(i * 29 + 5)};
  endfunction
  assign src_rd_data = pat(int'(src_rd_idx));

  line_migrator #(.LINES(LINES), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .present_i(present),
    .wr_req_i(wr_req), .wr_idx_i(wr_idx), .wr_stall_o(wr_stall),
    .rd_idx_i(rd_idx), .rd_from_dst_o(rd_dst), .busy_o(busy), .swap_o(swap),
    .src_rd_valid_o(src_rd_valid), .src_rd_idx_o(src_rd_idx),
    .src_rd_ready_i(src_rd_ready), .src_rd_data_i(src_rd_data),
    .dst_wr_valid_o(dst_wr_valid), .dst_wr_idx_o(dst_wr_idx),
    .dst_wr_data_o(dst_wr_data), .dst_wr_ready_i(dst_wr_ready),
    .src_inv_valid_o(src_inv_valid), .src_inv_idx_o(src_inv_idx),
    .src_inv_ready_i(src_inv_ready)
  );

  int total = 0, fails = 0, cyc = 0, swaps = 0;
  bit moved [LINES];
  bit mbusy = 0;
  int stage = 0, inflight = -1;
  int order[$];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic int held_moved();
    int n = 0;
    for (int i = 0; i < LINES; i++) if (present[i] && moved[i]) n++;
    return n;
  endfunction

  // Behavioural reference: tracks moved lines from the bank handshakes.
  always @(negedge clk) begin
    if (rst_n) begin
      bit run;
      run = mbusy && !swap;
      if (swap) begin
        chk(!busy, "R9", "busy at swap", busy, 0);
        chk(mbusy, "R9", "swap while running", 1, mbusy);
        chk(held_moved() == $countones(present), "R9", "lines moved at swap", held_moved(), $countones(present));
        swaps++;
      end else chk(busy == mbusy, "R1", "busy flag", busy, mbusy);
      chk(rd_dst == (run && (moved[rd_idx] || !present[rd_idx])), "R5", "read routing", rd_dst,
          run && (moved[rd_idx] || !present[rd_idx]));
      chk(wr_stall == (wr_req && run && present[wr_idx] && !moved[wr_idx]), "R6", "write stall", wr_stall,
          wr_req && run && present[wr_idx] && !moved[wr_idx]);
      if (src_rd_valid && src_rd_ready) begin
        chk(present[src_rd_idx], "R3", "read of absent slot", src_rd_idx, -1);
        chk(!moved[src_rd_idx] && stage == 0, "R2", "read of moved line", src_rd_idx, stage);
        inflight = src_rd_idx; stage = 1; order.push_back(int'(src_rd_idx));
      end
      if (dst_wr_valid && dst_wr_ready) begin
        chk(stage == 1 && int'(dst_wr_idx) == inflight, "R2", "dest index", dst_wr_idx, inflight);
        chk(dst_wr_data == pat(int'(dst_wr_idx)), "R2", "dest data", dst_wr_data, pat(int'(dst_wr_idx)));
        stage = 2;
      end
      if (src_inv_valid && src_inv_ready) begin
        chk(stage == 2 && int'(src_inv_idx) == inflight, "R2", "invalidate index", src_inv_idx, inflight);
        moved[src_inv_idx] = 1; stage = 0;
      end
      if (swap) mbusy = 0;
      if (start && !mbusy) begin
        mbusy = 1;
        for (int i = 0; i < LINES; i++) moved[i] = 0;
      end
    end
  end

  always @(posedge clk) begin
    rd_idx <= rd_idx + IDX_W'(37);
    if (jitter) begin
      dst_wr_ready  <= ($urandom % 3) != 0;
      src_inv_ready <= ($urandom % 4) != 0;
    end else begin
      dst_wr_ready  <= 1'b1;
      src_inv_ready <= 1'b1;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R9", "watchdog cycles", cyc, 150000);
      finish_run();
    end
  end

  task automatic pulse_start();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic wait_swap();
    int s0 = swaps;
    while (swaps == s0) step();
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // Reset and idle behaviour (R1, R5, R6)
    present = '1; wr_req = 1'b1; wr_idx = 8'd9;
    step();
    chk(!busy && !swap, "R1", "idle after reset", busy, 0);
    chk(!wr_stall, "R6", "idle write not stalled", wr_stall, 0);
    chk(!rd_dst, "R5", "idle read routing", rd_dst, 0);
    wr_req = 1'b0;

    // Run A: sparse presence, no writes, second start mid-run (R1, R3, R4)
    for (int i = 0; i < LINES; i++) present[i] = (i % 5) != 3;
    order.delete();
    pulse_start();
    chk(busy, "R1", "busy after start", busy, 1);
    repeat (120) step();
    pulse_start();
    chk(busy, "R1", "start while busy ignored", busy, 1);
    wait_swap();
    chk(order.size() == $countones(present), "R2", "line count run A", order.size(), $countones(present));
    for (int i = 1; i < order.size(); i++)
      chk(order[i] > order[i-1], "R4", "ascending order", order[i], order[i-1] + 1);

    // Run B: priority writes with a stuck source read (R7, R8)
    present = '1; jitter = 1'b1; src_rd_ready = 1'b0; order.delete();
    pulse_start();
    while (!src_rd_valid) step();
    wr_req = 1'b1; wr_idx = 8'd200;
    repeat (2) step();
    chk(wr_stall, "R7", "write to unmoved line stalled", wr_stall, 1);
    wr_idx = 8'd201;
    repeat (3) step();
    src_rd_ready = 1'b1;
    while (wr_stall) step();
    wr_req = 1'b0;
    wait_swap();
    chk(order.size() == LINES, "R2", "line count run B", order.size(), LINES);
    chk(order[0] == 0, "R4", "first line", order[0], 0);
    chk(order[1] == 200, "R7", "priority line next", order[1], 200);
    chk(order[2] == 201, "R8", "held slot kept, later write after", order[2], 201);
    chk(order[3] == 1, "R4", "sweep resumes", order[3], 1);

    // Run C: empty source bank (R3, R9)
    jitter = 1'b0; present = '0; order.delete();
    pulse_start();
    wr_req = 1'b1; wr_idx = 8'd17;
    step();
    chk(!wr_stall, "R6", "absent slot write not stalled", wr_stall, 0);
    wr_req = 1'b0;
    wait_swap();
    chk(order.size() == 0, "R3", "no bank traffic", order.size(), 0);
    chk(!busy, "R9", "idle after swap", busy, 0);
    finish_run();
  end
endmodule